// File: doc/BRIEF.md
# Ultra DMA Host Data-Out Burst Sequencer

This block sits on the host side of a parallel disk link. It drives an Ultra DMA data-out burst from start to finish. Once the device requests service and the host asks for a burst, the block pulls the acknowledge line low. It then makes one strobe transition for each word taken from a transmit source, and folds every word into a running 16-bit CRC. The device can hold off the transfer through its active-low ready line. The block stops toggling a bounded number of cycles after that line goes inactive. It resumes only after the line has been seen active for a full synchronized cycle.

A termination request starts an ordered shutdown:

1. Strobe edges stop.
2. STOP is raised once a programmable settle time has passed since the last edge.
3. When the device drops its request line, a low strobe is pulled high with no data, and the CRC goes onto the data bus.
4. The acknowledge line is released only after two programmable waits have both run out.

The two device inputs pass through synchronizers. All delays are counted in clock cycles.

Top module: `udma_host_burst_term`

## Requirements
- R1: While reset is held and right after it, host_ack_n_o is 1, stop_o is 0, wr_strobe_o is 1, done_o is 0 and tx_pop_o is 0.
- R2: A start_i pulse sampled in idle drives host_ack_n_o low at that clock edge, but only if the synchronized device request is high. With the request low, the pulse is ignored and host_ack_n_o stays 1.
- R3: Each strobe transition takes place at the clock edge where tx_pop_o was high just before. It puts tx_data_i on data_o. Transitions need tx_valid_i and are spaced exactly cfg_cyc_i cycles apart (the first one counts from the start edge) while the device stays ready.
- R4: When dev_rdy_n_i goes high, no strobe transition occurs more than one clock edge after the first edge that sees it high. After dev_rdy_n_i returns low, the next transition comes no earlier than the third clock edge, and the words continue in order.
- R5: After stop_req_i is sampled, the strobe does not change. stop_o rises at edge max(L + cfg_ss_i, Q + 1), where L is the last strobe edge (or the start edge) and Q is the request edge. stop_o stays high until the release is complete.
- R6: The synchronized request goes low two edges after dev_req_i does. At the following edge a low strobe is raised. This park edge pops no word, and the strobe does not fall again during shutdown.
- R7: At that same edge data_o carries the CRC of all words sent. The CRC starts from 16'h4ABA and uses polynomial 16'h1021. Each word is shifted in MSB first, one bit at a time: feedback is crc[15] XOR data bit.
- R8: Let C be the park edge and F the later of C and the edge at which synchronized ready goes inactive. host_ack_n_o rises at edge max(F + cfg_mli_i, C + cfg_dvs_i). All timing settings are at least 1.
- R9: done_o is high for exactly the one cycle after host_ack_n_o rises. stop_o falls together with it, and the block is then idle and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to open a data-out burst |
| stop_req_i | input | 1 | Request to end the current burst |
| tx_data_i | input | 16 | Next word from the transmit source |
| tx_valid_i | input | 1 | tx_data_i holds a word to send |
| tx_pop_o | output | 1 | The word on tx_data_i is taken at this clock edge |
| dev_req_i | input | 1 | Device request line (asynchronous) |
| dev_rdy_n_i | input | 1 | Device ready, active low (asynchronous) |
| cfg_cyc_i | input | CNT_W | Minimum cycles between strobe edges |
| cfg_ss_i | input | CNT_W | Cycles from last strobe edge to STOP |
| cfg_mli_i | input | CNT_W | Cycles of quiet bus before acknowledge release |
| cfg_dvs_i | input | CNT_W | Cycles the CRC is held on the bus before release |
| wr_strobe_o | output | 1 | Host write strobe |
| stop_o | output | 1 | STOP line to the device |
| host_ack_n_o | output | 1 | Acknowledge, active low |
| data_o | output | 16 | Data bus: words, then the CRC |
| done_o | output | 1 | One-cycle pulse when the burst has ended |

## Verification
The main sweep runs bursts of zero to three words under two strobe spacings and two settle times, with the two release waits set in both orders. Odd and even word counts leave the strobe low or high, so the park edge is seen both when it matters and when it must not occur. The zero-word burst shows that the STOP delay counts from the start edge. Swapping which release wait is longer shows whether the acknowledge release follows the quiet-bus condition or the CRC hold time. A separate long burst pauses in the middle, which tells apart a sequencer that keeps toggling and one that resumes too early or drops or repeats words.

// File: rtl/udma_hterm_pkg.sv
package udma_hterm_pkg;

    localparam int unsigned BUS_W = 16;
    localparam logic [BUS_W-1:0] CRC_SEED = 16'h4ABA;
    localparam logic [BUS_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        S_IDLE,
        S_XFER,
        S_SETTLE,
        S_STOPPED,
        S_HOLD,
        S_DONE
    } seq_state_e;

    // Commands from the sequencer to the strobe/data path
    typedef struct packed {
        logic init;     // burst opens: reseed CRC, strobe high
        logic toggle;   // data edge: flip strobe, drive word, fold CRC
        logic park;     // raise strobe without data
        logic crc_out;  // put CRC on the bus
    } path_ctl_t;

    // One word folded into the CRC, most significant bit first
    function automatic logic [BUS_W-1:0] crc_step(input logic [BUS_W-1:0] c,
                                                  input logic [BUS_W-1:0] w);
        logic [BUS_W-1:0] r;
        r = c;
        for (int i = BUS_W - 1; i >= 0; i--) begin
            if (r[BUS_W-1] ^ w[i]) r = {r[BUS_W-2:0], 1'b0} ^ CRC_POLY;
            else                   r = {r[BUS_W-2:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/udma_hterm_sync.sv
module udma_hterm_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RST_VAL;
                    else     chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RST_VAL;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/udma_hterm_path.sv
module udma_hterm_path
    import udma_hterm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  path_ctl_t        ctl_i,
    input  logic [BUS_W-1:0] tx_word_i,
    output logic             strobe_o,
    output logic [BUS_W-1:0] bus_o,
    output logic [BUS_W-1:0] crc_o
);
    logic             strobe_q;
    logic [BUS_W-1:0] bus_q;
    logic [BUS_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
            bus_q    <= '0;
            crc_q    <= CRC_SEED;
        end else if (ctl_i.init) begin
            strobe_q <= 1'b1;
            crc_q    <= CRC_SEED;
        end else if (ctl_i.toggle) begin
            strobe_q <= ~strobe_q;
            bus_q    <= tx_word_i;
            crc_q    <= crc_step(crc_q, tx_word_i);
        end else begin
            if (ctl_i.park)    strobe_q <= 1'b1;
            if (ctl_i.crc_out) bus_q    <= crc_q;
        end
    end

    // R6: a park command always leaves the strobe high
    p_park_high_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_i.park |=> strobe_q);

    // R7: CRC register is not disturbed by a park-only cycle
    p_park_keeps_crc_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.park && !ctl_i.toggle && !ctl_i.init) |=> $stable(crc_q));

    assign strobe_o = strobe_q;
    assign bus_o    = bus_q;
    assign crc_o    = crc_q;
endmodule

// File: rtl/udma_hterm_seq.sv
module udma_hterm_seq
    import udma_hterm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_req_i,
    input  logic             tx_valid_i,
    input  logic             req_s_i,
    input  logic             rdy_s_i,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] cfg_cyc_i,
    input  logic [CNT_W-1:0] cfg_ss_i,
    input  logic [CNT_W-1:0] cfg_mli_i,
    input  logic [CNT_W-1:0] cfg_dvs_i,
    output path_ctl_t        ctl_o,
    output logic             tx_pop_o,
    output logic             stop_o,
    output logic             ack_n_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W:0]   ONE_X   = (CNT_W+1)'(1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] gap_q, mli_q, dvs_q;
    logic             rdy_d1_q, stop_q, ack_n_q, done_q;
    logic             launch, fire, quiet, hold_ok, settle_ok, release_now;

    function automatic logic reached(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] lim);
        return ({1'b0, c} + ONE_X) >= {1'b0, lim};
    endfunction

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? c : c + 1'b1;
    endfunction

    always_comb begin
        launch      = (st_q == S_IDLE) && start_i && req_s_i;
        fire        = (st_q == S_XFER) && !stop_req_i && tx_valid_i
                      && rdy_s_i && rdy_d1_q && reached(gap_q, cfg_cyc_i);
        settle_ok   = (st_q == S_SETTLE) && reached(gap_q, cfg_ss_i);
        quiet       = (st_q == S_STOPPED) && !req_s_i;
        hold_ok     = strobe_i && stop_q && !req_s_i && !rdy_s_i;
        release_now = (st_q == S_HOLD) && hold_ok
                      && reached(mli_q, cfg_mli_i) && reached(dvs_q, cfg_dvs_i);
        ctl_o       = '{init: launch, toggle: fire, park: quiet, crc_out: quiet};
        tx_pop_o    = fire;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:    if (launch)      st_d = S_XFER;
            S_XFER:    if (stop_req_i)  st_d = S_SETTLE;
            S_SETTLE:  if (settle_ok)   st_d = S_STOPPED;
            S_STOPPED: if (quiet)       st_d = S_HOLD;
            S_HOLD:    if (release_now) st_d = S_DONE;
            S_DONE:                     st_d = S_IDLE;
            default:                    st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            gap_q    <= '0;
            mli_q    <= '0;
            dvs_q    <= '0;
            rdy_d1_q <= 1'b0;
            stop_q   <= 1'b0;
            ack_n_q  <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            st_q     <= st_d;
            rdy_d1_q <= rdy_s_i;
            gap_q    <= (launch || fire) ? '0 : bump(gap_q);
            mli_q    <= (quiet || !hold_ok) ? '0 : bump(mli_q);
            dvs_q    <= quiet ? '0 : bump(dvs_q);
            done_q   <= (st_q == S_DONE);
            if (settle_ok)           stop_q <= 1'b1;
            else if (st_q == S_DONE) stop_q <= 1'b0;
            if (launch)              ack_n_q <= 1'b0;
            else if (release_now)    ack_n_q <= 1'b1;
        end
    end

    // R5: STOP only drops at the close of the handshake
    p_stop_held_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_q) |-> $past(st_q == S_DONE));

    // R2: acknowledge only falls when a request was seen
    p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n_q) |-> $past(req_s_i && start_i));

    assign stop_o  = stop_q;
    assign ack_n_o = ack_n_q;
    assign done_o  = done_q;
endmodule

// File: rtl/udma_host_burst_term.sv
module udma_host_burst_term
    import udma_hterm_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_req_i,
    input  logic [15:0]      tx_data_i,
    input  logic             tx_valid_i,
    output logic             tx_pop_o,
    input  logic             dev_req_i,
    input  logic             dev_rdy_n_i,
    input  logic [CNT_W-1:0] cfg_cyc_i,
    input  logic [CNT_W-1:0] cfg_ss_i,
    input  logic [CNT_W-1:0] cfg_mli_i,
    input  logic [CNT_W-1:0] cfg_dvs_i,
    output logic             wr_strobe_o,
    output logic             stop_o,
    output logic             host_ack_n_o,
    output logic [15:0]      data_o,
    output logic             done_o
);
    logic       req_s, rdy_n_s, rdy_s;
    path_ctl_t  ctl;
    logic [15:0] crc_w;

    udma_hterm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk(clk), .rst(rst), .async_i(dev_req_i), .sync_o(req_s)
    );

    udma_hterm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
        .clk(clk), .rst(rst), .async_i(dev_rdy_n_i), .sync_o(rdy_n_s)
    );

    assign rdy_s = ~rdy_n_s;

    udma_hterm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .start_i(start_i), .stop_req_i(stop_req_i), .tx_valid_i(tx_valid_i),
        .req_s_i(req_s), .rdy_s_i(rdy_s), .strobe_i(wr_strobe_o),
        .cfg_cyc_i(cfg_cyc_i), .cfg_ss_i(cfg_ss_i),
        .cfg_mli_i(cfg_mli_i), .cfg_dvs_i(cfg_dvs_i),
        .ctl_o(ctl), .tx_pop_o(tx_pop_o), .stop_o(stop_o),
        .ack_n_o(host_ack_n_o), .done_o(done_o)
    );

    udma_hterm_path u_path (
        .clk(clk), .rst(rst), .ctl_i(ctl), .tx_word_i(tx_data_i),
        .strobe_o(wr_strobe_o), .bus_o(data_o), .crc_o(crc_w)
    );

    // Checker support: cycles since the strobe last changed
    logic [CNT_W-1:0] edge_age_q;
    logic             strobe_prev_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_age_q    <= '0;
            strobe_prev_q <= 1'b1;
        end else begin
            strobe_prev_q <= wr_strobe_o;
            if (host_ack_n_o || (wr_strobe_o != strobe_prev_q)) edge_age_q <= '0;
            else if (edge_age_q != '1)                          edge_age_q <= edge_age_q + 1'b1;
        end
    end

    // R3: every pop is matched by a strobe change
    p_pop_makes_edge_r3: assert property (@(posedge clk) disable iff (rst)
        tx_pop_o |=> (wr_strobe_o != $past(wr_strobe_o)));

    // R5: STOP keeps its distance from the last strobe edge
    p_stop_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_o) |-> (({1'b0, edge_age_q} + 1'b1) >= {1'b0, cfg_ss_i}));

    // R6: once STOP is up the strobe never falls
    p_no_fall_in_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_o && $past(stop_o)) |-> !$fell(wr_strobe_o));

    // R7: the bus carries the CRC when the acknowledge is released
    p_crc_at_release_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ack_n_o) |-> (data_o == crc_w));

    // R8: release only with strobe high, STOP up, request and ready gone
    p_release_cond_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ack_n_o) |-> $past(wr_strobe_o && stop_o && !req_s && !rdy_s));

    // R9: done follows release by one cycle and STOP drops with it
    p_done_follows_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ack_n_o) |=> (done_o && !stop_o));
endmodule

// File: tb/udma_host_burst_term_tb_top.sv
module udma_host_burst_term_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0, stop_req_i = 1'b0, tx_valid_i = 1'b0;
    logic [15:0]   tx_data_i = '0;
    logic          dev_req_i = 1'b0, dev_rdy_n_i = 1'b1;
    logic [CW-1:0] cfg_cyc_i = 8'd1, cfg_ss_i = 8'd1, cfg_mli_i = 8'd1, cfg_dvs_i = 8'd1;
    logic          tx_pop_o, wr_strobe_o, stop_o, host_ack_n_o, done_o;
    logic [15:0]   data_o;

    always #10 clk = ~clk;   // 50 MHz

    udma_host_burst_term #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_req_i(stop_req_i),
        .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_pop_o(tx_pop_o),
        .dev_req_i(dev_req_i), .dev_rdy_n_i(dev_rdy_n_i),
        .cfg_cyc_i(cfg_cyc_i), .cfg_ss_i(cfg_ss_i), .cfg_mli_i(cfg_mli_i),
        .cfg_dvs_i(cfg_dvs_i), .wr_strobe_o(wr_strobe_o), .stop_o(stop_o),
        .host_ack_n_o(host_ack_n_o), .data_o(data_o), .done_o(done_o)
    );

    int          n_chk = 0, n_bad = 0;
    longint      now = 0;
    bit          finished = 0;
    bit          data_phase = 0, exact_gap = 1;
    int          k = 0, n_words = 0, cyc_cfg = 1;
    longint      last_edge = 0, pause_from = -1, resume_from = -1;
    logic        prev_strb = 1'b1;
    logic [15:0] crc_m = 16'h4ABA;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, now);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [15:0] word_of(input int idx);
        return 16'(idx) * 16'h9E37 + 16'h1F03;
    endfunction

    // R7 model: shift register, MSB first, poly 0x1021
    function automatic logic [15:0] bench_crc(input logic [15:0] c, input logic [15:0] w);
        int acc;
        acc = int'(c);
        for (int b = 15; b >= 0; b--) begin
            int fb;
            fb  = ((acc >> 15) & 1) ^ ((int'(w) >> b) & 1);
            acc = ((acc << 1) & 16'hFFFF) ^ (fb != 0 ? 16'h1021 : 0);
        end
        return acc[15:0];
    endfunction

    function automatic longint maxl(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    task automatic tick();
        bit pop_seen, changed;
        #1 pop_seen = tx_pop_o;
        @(posedge clk);
        now++;
        @(negedge clk);
        changed = (wr_strobe_o !== prev_strb);
        if (data_phase) begin
            chk(changed == pop_seen, "R3 edge/pop", changed, pop_seen);
            if (changed) begin
                chk(data_o == word_of(k), "R3 word", data_o, word_of(k));
                if (exact_gap) chk(now - last_edge == cyc_cfg, "R3 spacing", now - last_edge, cyc_cfg);
                else           chk(now - last_edge >= cyc_cfg, "R3 spacing", now - last_edge, cyc_cfg);
                if (pause_from >= 0)
                    chk(now <= pause_from + 1, "R4 late edge", now, pause_from + 1);
                if (resume_from >= 0) begin
                    chk(now >= resume_from + 3, "R4 early resume", now, resume_from + 3);
                    resume_from = -1;
                end
                crc_m = bench_crc(crc_m, word_of(k));
                k++;
                last_edge  = now;
                tx_data_i  = word_of(k);
                tx_valid_i = (k < n_words);
            end
        end else if (pop_seen) begin
            chk(0, "R6 pop outside data phase", 1, 0);
        end
        prev_strb = wr_strobe_o;
    endtask

    task automatic run_burst(input int n, input int cyc, input int tss, input int tmli,
                             input int tdvs, input int dq_wait, input int rd_wait, input int pause_at);
        longint q, e, exp_e, d1, c, rd, f, r;
        logic   lvl, strb_hold;
        bit     pdone;
        int     guard;
        cfg_cyc_i = CW'(cyc); cfg_ss_i = CW'(tss); cfg_mli_i = CW'(tmli); cfg_dvs_i = CW'(tdvs);
        cyc_cfg = cyc; n_words = n; k = 0; crc_m = 16'h4ABA;
        tx_data_i = word_of(0); tx_valid_i = (n > 0);
        exact_gap = 1; pause_from = -1; resume_from = -1; pdone = 0;

        start_i = 1'b1; tick(); start_i = 1'b0;
        last_edge = now;
        chk(host_ack_n_o == 1'b0, "R2 ack low", host_ack_n_o, 0);
        chk(stop_o == 1'b0, "R2 stop low", stop_o, 0);
        data_phase = 1;
        guard = 0;
        while (k < n && guard < 500) begin
            if (k == pause_at && !pdone) begin
                dev_rdy_n_i = 1'b1; pause_from = now + 1; exact_gap = 0;
                repeat (10) tick();
                chk(k <= pause_at + 2, "R4 words in pause", k, pause_at + 2);
                dev_rdy_n_i = 1'b0; pause_from = -1; resume_from = now + 1; pdone = 1;
            end
            tick();
            guard++;
        end
        chk(k == n, "R3 word count", k, n);
        repeat (2) tick();
        data_phase = 0;
        strb_hold = wr_strobe_o;

        stop_req_i = 1'b1; tick(); q = now; stop_req_i = 1'b0;
        exp_e = maxl(last_edge + tss, q + 1);
        e = -1;
        for (int i = 0; i < 100 && e < 0; i++) begin
            if (stop_o) e = now; else tick();
        end
        chk(e == exp_e, "R5 stop edge", e, exp_e);
        chk(wr_strobe_o == strb_hold, "R5 strobe frozen", wr_strobe_o, strb_hold);

        repeat (dq_wait) tick();
        dev_req_i = 1'b0; tick(); d1 = now;
        lvl = wr_strobe_o;
        tick();
        chk(wr_strobe_o == lvl, "R6 no early park", wr_strobe_o, lvl);
        tick(); c = now;
        chk(wr_strobe_o == 1'b1, "R6 parked high", wr_strobe_o, 1);
        chk(data_o == crc_m, "R7 crc on bus", data_o, crc_m);
        chk(stop_o == 1'b1, "R5 stop held", stop_o, 1);

        repeat (rd_wait) tick();
        dev_rdy_n_i = 1'b1; tick(); rd = now;
        f = maxl(c, rd + 1);
        r = maxl(f + tmli, c + tdvs);
        while (now < r - 1) begin
            chk(host_ack_n_o == 1'b0, "R8 early release", host_ack_n_o, 0);
            tick();
        end
        chk(host_ack_n_o == 1'b0, "R8 early release", host_ack_n_o, 0);
        tick();
        chk(host_ack_n_o == 1'b1, "R8 release edge", host_ack_n_o, 1);
        chk(done_o == 1'b0, "R9 done not yet", done_o, 0);
        tick();
        chk(done_o == 1'b1, "R9 done pulse", done_o, 1);
        chk(stop_o == 1'b0, "R9 stop dropped", stop_o, 0);
        tick();
        chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        chk(wr_strobe_o == 1'b1, "R6 strobe stays high", wr_strobe_o, 1);

        dev_req_i = 1'b1; dev_rdy_n_i = 1'b0;
        repeat (4) tick();
        chk(host_ack_n_o == 1'b1, "R9 idle after burst", host_ack_n_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(host_ack_n_o == 1'b1, "R1 ack", host_ack_n_o, 1);
        chk(stop_o == 1'b0, "R1 stop", stop_o, 0);
        chk(wr_strobe_o == 1'b1, "R1 strobe", wr_strobe_o, 1);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(tx_pop_o == 1'b0, "R1 pop", tx_pop_o, 0);

        // R2: start without device request is ignored
        start_i = 1'b1; tick(); start_i = 1'b0; tick();
        chk(host_ack_n_o == 1'b1, "R2 start ignored", host_ack_n_o, 1);

        dev_req_i = 1'b1; dev_rdy_n_i = 1'b0;
        repeat (4) tick();

        for (int n = 0; n < 4; n++)
            for (int cy = 1; cy <= 3; cy += 2)
                for (int ss = 1; ss <= 4; ss += 3)
                    for (int mode = 0; mode < 2; mode++)
                        run_burst(n, cy, ss, mode ? 6 : 1, mode ? 2 : 5,
                                  n % 3, (n + mode) % 3, -1);

        // R4: pause in the middle of a long burst
        run_burst(14, 2, 2, 3, 3, 1, 2, 5);
        run_burst(9, 1, 3, 2, 4, 0, 1, 3);

        summary();
    end
endmodule